// File: doc/BRIEF.md
# Stack Expression Engine

This block evaluates integer expressions without naming any operands. Each command either places a word on an operand stack, removes the top word, or applies an arithmetic operator to the two topmost words and leaves the result in their place. The four newest entries sit in registers next to the arithmetic unit. Older entries move to a small internal spill memory when the register window fills, and they come back one at a time as the window drains.

A host feeds one command per cycle while `ready` is high. Multiply and divide take one extra cycle, and `ready` drops during that cycle. A pop returns the removed word on `resultData` and raises `resultValid` for one cycle. Three sticky flags report misuse: taking too many items off the stack, pushing past its capacity, and dividing by zero. Only reset clears them.

Top module: `stack_alu`

## Requirements
- R1: After reset, `ready` is high, `resultValid` is low, all three error flags are low and the stack is empty.
- R2: A command is taken at a rising edge where `cmdValid` and `ready` are both high. Push writes `cmdData` onto the stack. Pop removes the top entry, places it on `resultData` and holds `resultValid` high for the single cycle after it is taken. Entries come back in last-in, first-out order.
- R3: Add and subtract use the entry below the top as the left operand and the top entry as the right operand. They replace both entries with the result, taken modulo 2^32, so the depth drops by one.
- R4: Multiply keeps the low 32 bits of the product. After a multiply or divide is taken, `ready` is low for exactly one cycle and then returns high.
- R5: Divide is signed and truncates toward zero. The most negative value divided by -1 gives the most negative value.
- R6: A divide with a zero top entry replaces both operands with 0 and sets the sticky flag `divZeroErr`.
- R7: The stack holds up to 4 + SPILL_DEPTH entries. Every entry comes back in order, including entries that passed through the spill memory and entries refilled after a binary operation.
- R8: A push onto a full stack sets the sticky flag `overflowErr`. The pushed word is dropped and the existing contents stay unchanged.
- R9: A pop on an empty stack, or a binary operator with fewer than two entries, sets the sticky flag `underflowErr` and leaves the stack unchanged. Such a pop does not raise `resultValid`.
- R10: Opcodes are 0 no-op, 1 push, 2 pop, 3 add, 4 subtract, 5 multiply, 6 divide, and 7 reserved. Opcodes 0 and 7 have no effect, and neither has any cycle with `cmdValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is presented |
| cmdOp | input | 3 | Opcode (see R10) |
| cmdData | input | DATA_W | Word for push |
| ready | output | 1 | Block accepts a command this cycle |
| resultValid | output | 1 | `resultData` holds a popped word |
| resultData | output | DATA_W | Last popped word |
| underflowErr | output | 1 | Sticky: too few entries for a command |
| overflowErr | output | 1 | Sticky: push onto a full stack |
| divZeroErr | output | 1 | Sticky: divide by zero |

## Verification
Some properties are checked on every cycle: the one-cycle stall after multiply and divide, a valid result only after an accepted pop, the stickiness of the flags, and the rule that the spill memory holds data only while the register window is full. The same checks cover depth that stays frozen on overflow and on empty pops. Other behaviour only the bench scenarios can show: the arithmetic values, operand order, rounding toward zero, and the order in which words return after spilling and refilling.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_MUL  = 3'd5,
    OP_DIV  = 3'd6,
    OP_RSV  = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2,
    ALU_DIV = 2'd3
  } aluSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    doPush;
    logic    doPop;
    logic    doBin;
    logic    spill;
    logic    refill;
    logic    latchOps;
    aluSel_e aluSel;
  } dpCtl_t;

endpackage

// File: rtl/stack_alu_ctrl.sv
module stack_alu_ctrl
  import stack_alu_pkg::*;
#(
  parameter int SPILL_DEPTH = 8,
  localparam int CW = $clog2(SPILL_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic          divisorZero,
  output logic          ready,
  output dpCtl_t        ctl,
  output logic [CW-1:0] ramCount,
  output logic [2:0]    regCount,
  output logic          underflowErr,
  output logic          overflowErr,
  output logic          divZeroErr
);

  opcode_e op;
  logic    busy;
  aluSel_e pendSel;
  logic    regFull, ramFull, ramAny, fewOperands;
  logic    udfSet, ovfSet, dzSet;

  assign op          = opcode_e'(cmdOp);
  assign regFull     = (regCount == 3'd4);
  assign ramFull     = (ramCount == CW'(SPILL_DEPTH));
  assign ramAny      = (ramCount != '0);
  assign fewOperands = (regCount < 3'd2);
  assign ready       = !busy;

  always_comb begin
    ctl    = '0;
    udfSet = 1'b0;
    ovfSet = 1'b0;
    dzSet  = 1'b0;
    if (busy) begin
      ctl.doBin  = 1'b1;
      ctl.aluSel = pendSel;
      ctl.refill = ramAny;
      dzSet      = (pendSel == ALU_DIV) && divisorZero;
    end else if (cmdValid) begin
      unique case (op)
        OP_PUSH: begin
          if (regFull && ramFull) ovfSet = 1'b1;
          else begin
            ctl.doPush = 1'b1;
            ctl.spill  = regFull;
          end
        end
        OP_POP: begin
          if (regCount == 3'd0) udfSet = 1'b1;
          else begin
            ctl.doPop  = 1'b1;
            ctl.refill = ramAny;
          end
        end
        OP_ADD, OP_SUB: begin
          if (fewOperands) udfSet = 1'b1;
          else begin
            ctl.doBin  = 1'b1;
            ctl.refill = ramAny;
            ctl.aluSel = (op == OP_SUB) ? ALU_SUB : ALU_ADD;
          end
        end
        OP_MUL, OP_DIV: begin
          if (fewOperands) udfSet = 1'b1;
          else begin
            ctl.latchOps = 1'b1;
            ctl.aluSel   = (op == OP_DIV) ? ALU_DIV : ALU_MUL;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      pendSel      <= ALU_ADD;
      regCount     <= 3'd0;
      ramCount     <= '0;
      underflowErr <= 1'b0;
      overflowErr  <= 1'b0;
      divZeroErr   <= 1'b0;
    end else begin
      busy <= ctl.latchOps;
      if (ctl.latchOps) pendSel <= ctl.aluSel;
      if (ctl.doPush && !ctl.spill) regCount <= regCount + 3'd1;
      else if ((ctl.doPop || ctl.doBin) && !ctl.refill) regCount <= regCount - 3'd1;
      if (ctl.spill) ramCount <= ramCount + CW'(1);
      else if (ctl.refill) ramCount <= ramCount - CW'(1);
      if (udfSet) underflowErr <= 1'b1;
      if (ovfSet) overflowErr  <= 1'b1;
      if (dzSet)  divZeroErr   <= 1'b1;
    end
  end

endmodule

// File: rtl/stack_alu_dp.sv
module stack_alu_dp
  import stack_alu_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SPILL_DEPTH = 8,
  localparam int CW    = $clog2(SPILL_DEPTH + 1),
  localparam int AW    = (SPILL_DEPTH > 1) ? $clog2(SPILL_DEPTH) : 1,
  localparam int SLOTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [CW-1:0]     ramCount,
  output logic              divisorZero,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData
);

  localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] NEG_ONE = {DATA_W{1'b1}};

  logic [DATA_W-1:0] slot [SLOTS];
  logic [DATA_W-1:0] spillMem [SPILL_DEPTH];
  logic [DATA_W-1:0] opA, opB, aluOut, refillWord;

  assign refillWord  = spillMem[AW'(ramCount - CW'(1))];
  assign divisorZero = (opB == '0);

  always_comb begin
    unique case (ctl.aluSel)
      ALU_ADD: aluOut = slot[1] + slot[0];
      ALU_SUB: aluOut = slot[1] - slot[0];
      ALU_MUL: aluOut = opA * opB;
      default: begin
        if (divisorZero)                           aluOut = '0;
        else if (opA == MIN_VAL && opB == NEG_ONE) aluOut = MIN_VAL;
        else aluOut = DATA_W'($signed(opA) / $signed(opB));
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctl.spill) spillMem[AW'(ramCount)] <= slot[SLOTS-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
      opA         <= '0;
      opB         <= '0;
      resultValid <= 1'b0;
      resultData  <= '0;
    end else begin
      resultValid <= ctl.doPop;
      if (ctl.doPop) resultData <= slot[0];
      if (ctl.latchOps) begin
        opA <= slot[1];
        opB <= slot[0];
      end
      if (ctl.doPush) begin
        slot[0] <= cmdData;
        for (int i = 1; i < SLOTS; i++) slot[i] <= slot[i-1];
      end else if (ctl.doPop) begin
        for (int i = 0; i < SLOTS-1; i++) slot[i] <= slot[i+1];
        if (ctl.refill) slot[SLOTS-1] <= refillWord;
      end else if (ctl.doBin) begin
        slot[0] <= aluOut;
        for (int i = 1; i < SLOTS-1; i++) slot[i] <= slot[i+1];
        if (ctl.refill) slot[SLOTS-1] <= refillWord;
      end
    end
  end

endmodule

// File: rtl/stack_alu.sv
module stack_alu
  import stack_alu_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SPILL_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  output logic              ready,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              underflowErr,
  output logic              overflowErr,
  output logic              divZeroErr
);

  localparam int CW = $clog2(SPILL_DEPTH + 1);

  dpCtl_t        ctl;
  logic [CW-1:0] ramCount;
  logic [2:0]    regCount;
  logic          divisorZero;

  stack_alu_ctrl #(.SPILL_DEPTH(SPILL_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .divisorZero(divisorZero), .ready(ready), .ctl(ctl),
    .ramCount(ramCount), .regCount(regCount),
    .underflowErr(underflowErr), .overflowErr(overflowErr),
    .divZeroErr(divZeroErr)
  );

  stack_alu_dp #(.DATA_W(DATA_W), .SPILL_DEPTH(SPILL_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdData(cmdData),
    .ramCount(ramCount), .divisorZero(divisorZero),
    .resultValid(resultValid), .resultData(resultData)
  );

endmodule

// File: rtl/stack_alu_chk.sv
module stack_alu_chk #(
  parameter int SPILL_DEPTH = 8,
  localparam int CW = $clog2(SPILL_DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic [2:0]    cmdOp,
  input logic          ready,
  input logic          resultValid,
  input logic          underflowErr,
  input logic          overflowErr,
  input logic          divZeroErr,
  input logic [2:0]    regCount,
  input logic [CW-1:0] ramCount
);

  localparam int MAX_DEPTH = 4 + SPILL_DEPTH;

  logic [CW:0] depth;
  logic        taken;
  assign depth = (CW+1)'(regCount) + (CW+1)'(ramCount);
  assign taken = cmdValid && ready;

  // R4
  stall_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ready);

  // R4
  stall_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && (cmdOp == 3'd5 || cmdOp == 3'd6) && regCount >= 3'd2) |=> !ready);

  // R2
  pop_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(taken && cmdOp == 3'd2 && regCount != 3'd0));

  // R9
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  // R6
  divzero_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    divZeroErr |=> divZeroErr);

  // R7
  spill_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramCount != '0) |-> (regCount == 3'd4));

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regCount <= 3'd4) && (depth <= (CW+1)'(MAX_DEPTH)));

  // R8
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdOp == 3'd1 && depth == (CW+1)'(MAX_DEPTH)) |=> ($stable(depth) && overflowErr));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdOp == 3'd2 && depth == '0) |=> (depth == '0 && underflowErr && !resultValid));

endmodule

bind stack_alu stack_alu_chk #(.SPILL_DEPTH(SPILL_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .ready(ready), .resultValid(resultValid),
  .underflowErr(underflowErr), .overflowErr(overflowErr),
  .divZeroErr(divZeroErr), .regCount(regCount), .ramCount(ramCount)
);

// File: tb/stack_alu_bench.sv
`timescale 1ns/1ps
module stack_alu_bench;

  localparam int SPILL = 8;
  localparam int CAP   = 4 + SPILL;
  localparam int NV    = 58;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [31:0] cmdData = '0;
  logic        ready, resultValid, underflowErr, overflowErr, divZeroErr;
  logic [31:0] resultData;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  stack_alu #(.DATA_W(32), .SPILL_DEPTH(SPILL)) u_stack_alu (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .ready(ready), .resultValid(resultValid),
    .resultData(resultData), .underflowErr(underflowErr),
    .overflowErr(overflowErr), .divZeroErr(divZeroErr)
  );

  // {op, data, check, expected, req}
  localparam logic [71:0] VECS [NV] = '{
    // R2 last in, first out
    {3'd1, 32'd11, 1'b0, 32'd0, 4'd2}, {3'd1, 32'd22, 1'b0, 32'd0, 4'd2},
    {3'd2, 32'd0, 1'b1, 32'd22, 4'd2}, {3'd2, 32'd0, 1'b1, 32'd11, 4'd2},
    // R3 operand order and wrap
    {3'd1, 32'd7, 1'b0, 32'd0, 4'd3}, {3'd1, 32'd3, 1'b0, 32'd0, 4'd3},
    {3'd4, 32'd0, 1'b0, 32'd0, 4'd3}, {3'd2, 32'd0, 1'b1, 32'd4, 4'd3},
    {3'd1, 32'd3, 1'b0, 32'd0, 4'd3}, {3'd1, 32'd7, 1'b0, 32'd0, 4'd3},
    {3'd4, 32'd0, 1'b0, 32'd0, 4'd3}, {3'd2, 32'd0, 1'b1, 32'hFFFFFFFC, 4'd3},
    {3'd1, 32'hFFFFFFFF, 1'b0, 32'd0, 4'd3}, {3'd1, 32'd2, 1'b0, 32'd0, 4'd3},
    {3'd3, 32'd0, 1'b0, 32'd0, 4'd3}, {3'd2, 32'd0, 1'b1, 32'd1, 4'd3},
    // R4 multiply
    {3'd1, 32'd6, 1'b0, 32'd0, 4'd4}, {3'd1, 32'd7, 1'b0, 32'd0, 4'd4},
    {3'd5, 32'd0, 1'b0, 32'd0, 4'd4}, {3'd2, 32'd0, 1'b1, 32'd42, 4'd4},
    {3'd1, 32'd10000, 1'b0, 32'd0, 4'd4}, {3'd1, 32'd30000, 1'b0, 32'd0, 4'd4},
    {3'd5, 32'd0, 1'b0, 32'd0, 4'd4}, {3'd2, 32'd0, 1'b1, 32'd300000000, 4'd4},
    {3'd1, 32'hFFFFFFFE, 1'b0, 32'd0, 4'd4}, {3'd1, 32'd5, 1'b0, 32'd0, 4'd4},
    {3'd5, 32'd0, 1'b0, 32'd0, 4'd4}, {3'd2, 32'd0, 1'b1, 32'hFFFFFFF6, 4'd4},
    // R5 signed divide
    {3'd1, 32'hFFFFFFF9, 1'b0, 32'd0, 4'd5}, {3'd1, 32'd2, 1'b0, 32'd0, 4'd5},
    {3'd6, 32'd0, 1'b0, 32'd0, 4'd5}, {3'd2, 32'd0, 1'b1, 32'hFFFFFFFD, 4'd5},
    {3'd1, 32'd7, 1'b0, 32'd0, 4'd5}, {3'd1, 32'hFFFFFFFE, 1'b0, 32'd0, 4'd5},
    {3'd6, 32'd0, 1'b0, 32'd0, 4'd5}, {3'd2, 32'd0, 1'b1, 32'hFFFFFFFD, 4'd5},
    {3'd1, 32'h80000000, 1'b0, 32'd0, 4'd5}, {3'd1, 32'hFFFFFFFF, 1'b0, 32'd0, 4'd5},
    {3'd6, 32'd0, 1'b0, 32'd0, 4'd5}, {3'd2, 32'd0, 1'b1, 32'h80000000, 4'd5},
    {3'd1, 32'd2, 1'b0, 32'd0, 4'd5}, {3'd1, 32'd7, 1'b0, 32'd0, 4'd5},
    {3'd6, 32'd0, 1'b0, 32'd0, 4'd5}, {3'd2, 32'd0, 1'b1, 32'd0, 4'd5},
    // R3 (20-2)/(10-2*3)
    {3'd1, 32'd20, 1'b0, 32'd0, 4'd3}, {3'd1, 32'd2, 1'b0, 32'd0, 4'd3},
    {3'd4, 32'd0, 1'b0, 32'd0, 4'd3}, {3'd1, 32'd10, 1'b0, 32'd0, 4'd3},
    {3'd1, 32'd2, 1'b0, 32'd0, 4'd3}, {3'd1, 32'd3, 1'b0, 32'd0, 4'd3},
    {3'd5, 32'd0, 1'b0, 32'd0, 4'd3}, {3'd4, 32'd0, 1'b0, 32'd0, 4'd3},
    {3'd6, 32'd0, 1'b0, 32'd0, 4'd3}, {3'd2, 32'd0, 1'b1, 32'd4, 4'd3},
    // R10 no-op and reserved opcode
    {3'd1, 32'd5, 1'b0, 32'd0, 4'd10}, {3'd0, 32'd77, 1'b0, 32'd0, 4'd10},
    {3'd7, 32'd88, 1'b0, 32'd0, 4'd10}, {3'd2, 32'd0, 1'b1, 32'd5, 4'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] data);
    @(negedge clk);
    while (!ready) @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdData  = data;
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    summary();
  end

  initial begin
    doReset();
    #1;
    // R1 reset state
    check("R1 ready", {31'b0, ready}, 32'd1);
    check("R1 resultValid", {31'b0, resultValid}, 32'd0);
    check("R1 flags", {29'b0, underflowErr, overflowErr, divZeroErr}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      issue(VECS[v][71:69], VECS[v][68:37]);
      if (VECS[v][36]) begin
        check($sformatf("R%0d vector %0d valid", VECS[v][3:0], v), {31'b0, resultValid}, 32'd1);
        check($sformatf("R%0d vector %0d data", VECS[v][3:0], v), resultData, VECS[v][35:4]);
      end
    end
    check("R9 R8 R6 no flags after table", {29'b0, underflowErr, overflowErr, divZeroErr}, 32'd0);

    // R10 cycles with cmdValid low change nothing
    issue(3'd1, 32'd99);
    @(negedge clk);
    cmdOp = 3'd1; cmdData = 32'd55;
    repeat (3) @(negedge clk);
    issue(3'd2, 32'd0);
    check("R10 idle push ignored", resultData, 32'd99);
    // R9 pop on empty
    issue(3'd2, 32'd0);
    check("R9 empty pop no valid", {31'b0, resultValid}, 32'd0);
    check("R9 empty pop flag", {31'b0, underflowErr}, 32'd1);

    // R9 binary op with one entry leaves stack unchanged
    doReset();
    issue(3'd1, 32'd11);
    issue(3'd3, 32'd0);
    check("R9 add underflow flag", {31'b0, underflowErr}, 32'd1);
    issue(3'd2, 32'd0);
    check("R9 stack kept", resultData, 32'd11);

    // R4 one-cycle stall
    issue(3'd1, 32'd2);
    issue(3'd1, 32'd3);
    issue(3'd5, 32'd0);
    check("R4 ready low after mul", {31'b0, ready}, 32'd0);
    @(posedge clk); #1;
    check("R4 ready back", {31'b0, ready}, 32'd1);
    issue(3'd2, 32'd0);
    check("R4 product", resultData, 32'd6);

    // R6 divide by zero
    doReset();
    issue(3'd1, 32'd9);
    issue(3'd1, 32'd0);
    issue(3'd6, 32'd0);
    issue(3'd2, 32'd0);
    check("R6 zero pushed", resultData, 32'd0);
    check("R6 flag", {31'b0, divZeroErr}, 32'd1);
    check("R6 other flags clear", {30'b0, underflowErr, overflowErr}, 32'd0);

    // R7 R8 spill, refill, overflow
    doReset();
    for (int i = 1; i <= CAP; i++) issue(3'd1, 32'(i));
    check("R8 no flag at capacity", {31'b0, overflowErr}, 32'd0);
    issue(3'd1, 32'd500);
    check("R8 overflow flag", {31'b0, overflowErr}, 32'd1);
    issue(3'd3, 32'd0);
    issue(3'd2, 32'd0);
    check("R7 R8 add across refill", resultData, 32'(CAP + CAP - 1));
    for (int i = CAP - 2; i >= 1; i--) begin
      issue(3'd2, 32'd0);
      check($sformatf("R7 refill order %0d", i), resultData, 32'(i));
    end
    check("R7 no underflow", {31'b0, underflowErr}, 32'd0);
    issue(3'd2, 32'd0);
    check("R9 drained pop flag", {31'b0, underflowErr}, 32'd1);

    summary();
  end

endmodule